// File: doc/BRIEF.md
# Threshold-Split Receive Copy Engine

This block moves one received frame at a time from the receive FIFO into host memory. Software (or an upstream scheduler) offers copy requests. Each request names a host buffer address, a buffer length and an optional no-delay flag. The engine clamps the amount copied, asks an external DMA writer to move that many bytes from the current frame offset, and then reports the result as a single completion word. It also pulses the receive interrupt causes and keeps low and high occupancy flags for the FIFO.

When zero-copy or deferred-copy operation is selected and the FIFO has drained below its low mark, a large frame is not copied whole. Only a short leading piece, of a configured size, is delivered. The completion then says how many bytes remain and sets a more flag. Later continuation requests pick up the rest of that frame from where the last copy stopped. Continuation requests always win over requests for a fresh frame. A fresh frame is only taken once the partly delivered one is finished. Frame classification flags and FIFO storage live outside; this block sees the head frame's length and flags and the FIFO's frame count.

Both request kinds share one set of field inputs. The fields describe the continuation request whenever `contReqValid` is high, and the new-frame request otherwise.

Top module: `rxcopy_top`

## Requirements
- R1: The length of a copy is the smaller of the request's buffer length and the bytes still remaining in the frame. The copy starts at `dmaOffset`, the count of bytes already delivered from that frame.
- R2: The length from R1 is replaced by `cfgZcSize` when all of the following hold: zero-copy or deferred-copy mode is on, the request's no-delay flag is clear, the registered `rxLow` flag is set, and the R1 length exceeds `cfgZcThresh`.
- R3: A request whose buffer address equals 1 issues no DMA (`dmaReqValid` stays low). It completes as if the copy had been done, with the same length bookkeeping.
- R4: Each copy ends with exactly one cycle of `doneValid`. The completion word `doneWord` has these fields: bits [13:0] hold the length, bit 14 is the more flag, bit 15 is the complete flag (always 1), bit 16 is the error flag, and bits [20:17] hold the frame classification flags captured when the frame was taken.
- R5: When a copy covers all remaining bytes, the length field holds the copied length, the more flag is 0, and `framePop` is high during the `doneValid` cycle.
- R6: When a copy covers only part of the remaining bytes, the more flag is 1, the length field holds the bytes still remaining, `framePop` stays low, and the next copy of that frame starts at the advanced offset.
- R7: With a frame partly delivered, a continuation request is accepted (`contReqAck`) in preference to a simultaneous new-frame request. A new-frame request is not accepted until that frame is finished.
- R8: In the `doneValid` cycle `intrDma` is high, and `intrEmpty` is high exactly when the FIFO frame count after any pop is zero. From the next cycle `rxLow` shows whether that count is below `cfgLowMark`, and `rxHigh` shows whether it is above `cfgHighMark`.
- R9: A frame of length zero issues no DMA. It completes with the error flag set, length 0, and `framePop` high.
- R10: The configuration keeps `cfgZcSize` strictly below `cfgZcThresh` and never enables zero-copy and deferred-copy together.
- R11: After reset no acknowledge, DMA request, completion or interrupt is active, `rxLow` is 1 and `rxHigh` is 0.
- R12: While `dmaReqValid` is high and `dmaDone` has not arrived, the DMA address, length and offset stay constant and the request stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgZeroCopy | input | 1 | Zero-copy mode enable |
| cfgDeferCopy | input | 1 | Deferred-copy mode enable |
| cfgZcSize | input | 14 | Short copy length used when a copy is cut |
| cfgZcThresh | input | 14 | Length above which a copy may be cut |
| cfgLowMark | input | 4 | FIFO low watermark (frames) |
| cfgHighMark | input | 4 | FIFO high watermark (frames) |
| fifoCount | input | 4 | Frames currently held in the receive FIFO |
| frameValid | input | 1 | Head frame available |
| frameLen | input | 14 | Length of the head frame in bytes |
| frameFlags | input | 4 | Classification flags of the head frame |
| newReqValid | input | 1 | Request to copy a fresh frame |
| contReqValid | input | 1 | Request to continue the partly delivered frame |
| reqAddr | input | 16 | Host buffer address of the offered request |
| reqLen | input | 14 | Host buffer length of the offered request |
| reqNoDelay | input | 1 | Request forbids cutting the copy |
| newReqAck | output | 1 | New-frame request accepted this cycle |
| contReqAck | output | 1 | Continuation request accepted this cycle |
| dmaReqValid | output | 1 | DMA write request outstanding |
| dmaAddr | output | 16 | DMA destination address |
| dmaLen | output | 14 | DMA byte count |
| dmaOffset | output | 14 | Source offset inside the frame |
| dmaDone | input | 1 | DMA write finished |
| framePop | output | 1 | Remove the head frame from the FIFO |
| doneValid | output | 1 | Completion word valid |
| doneWord | output | 21 | Completion word |
| intrEmpty | output | 1 | Receive-empty interrupt cause pulse |
| intrDma | output | 1 | Receive-DMA interrupt cause pulse |
| rxLow | output | 1 | FIFO below low mark at the last copy end |
| rxHigh | output | 1 | FIFO above high mark at the last copy end |

## Verification
The assertions check several rules on every cycle: a held DMA request keeps its address, length and offset stable; the two acknowledges are never given together; every completion carries the complete flag and a DMA interrupt; a more flag never pops the frame; an error completion always pops with length zero; the sentinel address never reaches the DMA port. The length arithmetic can only be shown by the bench scenarios. This covers the minimum and cut rules across mode, no-delay and low-flag combinations, the offsets and remaining counts over a chain of partial copies, the watermark and empty results, and the precedence of continuation over a waiting new-frame request.

// File: rtl/rxcopy_pkg.sv
package rxcopy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BEGIN,
    ST_COPY,
    ST_DONE
  } copyState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeNew;   // load head frame and latch request
    logic takeCont;  // latch continuation request
    logic fixLen;    // register the clamped copy length
    logic finish;    // copy done: update bookkeeping and flags
  } copyStrobe_t;

endpackage

// File: rtl/rxcopy_ctrl.sv
module rxcopy_ctrl
  import rxcopy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        newReqValid,
  input  logic        contReqValid,
  input  logic        frameValid,
  input  logic        partial,
  input  logic        zeroLen,
  input  logic        sentinel,
  input  logic        dmaDone,
  output copyStrobe_t strb,
  output logic        newReqAck,
  output logic        contReqAck,
  output logic        dmaReqValid
);

  copyState_e st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext     = st;
    strb       = '0;
    newReqAck  = 1'b0;
    contReqAck = 1'b0;
    unique case (st)
      ST_IDLE, ST_WAIT: begin
        if (contReqValid && partial) begin
          contReqAck    = 1'b1;
          strb.takeCont = 1'b1;
          stNext        = ST_BEGIN;
        end else if (newReqValid && !partial && frameValid) begin
          newReqAck    = 1'b1;
          strb.takeNew = 1'b1;
          stNext       = ST_BEGIN;
        end else if (newReqValid || contReqValid) begin
          stNext = ST_WAIT;
        end else begin
          stNext = ST_IDLE;
        end
      end
      ST_BEGIN: begin
        strb.fixLen = 1'b1;
        stNext = (zeroLen || sentinel) ? ST_DONE : ST_COPY;
      end
      ST_COPY: begin
        if (dmaDone) stNext = ST_DONE;
      end
      ST_DONE: begin
        strb.finish = 1'b1;
        stNext = (newReqValid || contReqValid) ? ST_WAIT : ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign dmaReqValid = (st == ST_COPY);

endmodule

// File: rtl/rxcopy_dp.sv
module rxcopy_dp
  import rxcopy_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int ADDR_W = 16,
  parameter int FLAG_W = 4,
  parameter int CNT_W  = 4,
  localparam int WORD_W = LEN_W + 3 + FLAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  copyStrobe_t       strb,
  input  logic              cfgZeroCopy,
  input  logic              cfgDeferCopy,
  input  logic [LEN_W-1:0]  cfgZcSize,
  input  logic [LEN_W-1:0]  cfgZcThresh,
  input  logic [CNT_W-1:0]  cfgLowMark,
  input  logic [CNT_W-1:0]  cfgHighMark,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [FLAG_W-1:0] frameFlags,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqNoDelay,
  output logic              partial,
  output logic              zeroLen,
  output logic              sentinel,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  output logic [LEN_W-1:0]  dmaOffset,
  output logic              framePop,
  output logic              doneValid,
  output logic [WORD_W-1:0] doneWord,
  output logic              intrEmpty,
  output logic              intrDma,
  output logic              rxLow,
  output logic              rxHigh
);

  logic              frameActive;
  logic [LEN_W-1:0]  offsetQ, remainQ, copyLenQ, bufLenQ;
  logic [FLAG_W-1:0] flagsQ;
  logic [ADDR_W-1:0] addrQ;
  logic              noDelayQ;
  logic              rxLowQ, rxHighQ;

  logic [LEN_W-1:0]  baseLen, clampLen;
  logic              cutOn, coversAll;
  logic [CNT_W-1:0]  cntAfter;
  logic [LEN_W-1:0]  lenField;

  // R1/R2: length clamp
  always_comb begin
    baseLen  = (bufLenQ < remainQ) ? bufLenQ : remainQ;
    cutOn    = (cfgZeroCopy || cfgDeferCopy) && !noDelayQ && rxLowQ
               && (baseLen > cfgZcThresh);
    clampLen = cutOn ? cfgZcSize : baseLen;
  end

  assign coversAll = (copyLenQ == remainQ);
  assign cntAfter  = fifoCount - CNT_W'(framePop);
  assign lenField  = coversAll ? copyLenQ : (remainQ - copyLenQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      offsetQ     <= '0;
      remainQ     <= '0;
      copyLenQ    <= '0;
      bufLenQ     <= '0;
      flagsQ      <= '0;
      addrQ       <= '0;
      noDelayQ    <= 1'b0;
      rxLowQ      <= 1'b1;
      rxHighQ     <= 1'b0;
    end else begin
      if (strb.takeNew) begin
        frameActive <= 1'b1;
        offsetQ     <= '0;
        remainQ     <= frameLen;
        flagsQ      <= frameFlags;
      end
      if (strb.takeNew || strb.takeCont) begin
        addrQ    <= reqAddr;
        bufLenQ  <= reqLen;
        noDelayQ <= reqNoDelay;
      end
      if (strb.fixLen) copyLenQ <= clampLen;
      if (strb.finish) begin
        if (coversAll) begin
          frameActive <= 1'b0;
        end else begin
          offsetQ <= offsetQ + copyLenQ;
          remainQ <= remainQ - copyLenQ;
        end
        rxLowQ  <= (cntAfter < cfgLowMark);
        rxHighQ <= (cntAfter > cfgHighMark);
      end
    end
  end

  assign partial   = frameActive;
  assign zeroLen   = (remainQ == '0);
  assign sentinel  = (addrQ == ADDR_W'(1));
  assign dmaAddr   = addrQ;
  assign dmaLen    = copyLenQ;
  assign dmaOffset = offsetQ;

  assign doneValid = strb.finish;
  assign framePop  = strb.finish && coversAll;
  assign intrDma   = strb.finish;
  assign intrEmpty = strb.finish && (cntAfter == '0);
  assign doneWord  = {flagsQ, (remainQ == '0), 1'b1, !coversAll, lenField};
  assign rxLow     = rxLowQ;
  assign rxHigh    = rxHighQ;

endmodule

// File: rtl/rxcopy_top.sv
module rxcopy_top
  import rxcopy_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int ADDR_W = 16,
  parameter int FLAG_W = 4,
  parameter int CNT_W  = 4,
  localparam int WORD_W = LEN_W + 3 + FLAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgZeroCopy,
  input  logic              cfgDeferCopy,
  input  logic [LEN_W-1:0]  cfgZcSize,
  input  logic [LEN_W-1:0]  cfgZcThresh,
  input  logic [CNT_W-1:0]  cfgLowMark,
  input  logic [CNT_W-1:0]  cfgHighMark,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic              frameValid,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [FLAG_W-1:0] frameFlags,
  input  logic              newReqValid,
  input  logic              contReqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqNoDelay,
  output logic              newReqAck,
  output logic              contReqAck,
  output logic              dmaReqValid,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  output logic [LEN_W-1:0]  dmaOffset,
  input  logic              dmaDone,
  output logic              framePop,
  output logic              doneValid,
  output logic [WORD_W-1:0] doneWord,
  output logic              intrEmpty,
  output logic              intrDma,
  output logic              rxLow,
  output logic              rxHigh
);

  copyStrobe_t strb;
  logic        partial, zeroLen, sentinel;

  rxcopy_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .newReqValid  (newReqValid),
    .contReqValid (contReqValid),
    .frameValid   (frameValid),
    .partial      (partial),
    .zeroLen      (zeroLen),
    .sentinel     (sentinel),
    .dmaDone      (dmaDone),
    .strb         (strb),
    .newReqAck    (newReqAck),
    .contReqAck   (contReqAck),
    .dmaReqValid  (dmaReqValid)
  );

  rxcopy_dp #(
    .LEN_W  (LEN_W),
    .ADDR_W (ADDR_W),
    .FLAG_W (FLAG_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgZeroCopy  (cfgZeroCopy),
    .cfgDeferCopy (cfgDeferCopy),
    .cfgZcSize    (cfgZcSize),
    .cfgZcThresh  (cfgZcThresh),
    .cfgLowMark   (cfgLowMark),
    .cfgHighMark  (cfgHighMark),
    .fifoCount    (fifoCount),
    .frameLen     (frameLen),
    .frameFlags   (frameFlags),
    .reqAddr      (reqAddr),
    .reqLen       (reqLen),
    .reqNoDelay   (reqNoDelay),
    .partial      (partial),
    .zeroLen      (zeroLen),
    .sentinel     (sentinel),
    .dmaAddr      (dmaAddr),
    .dmaLen       (dmaLen),
    .dmaOffset    (dmaOffset),
    .framePop     (framePop),
    .doneValid    (doneValid),
    .doneWord     (doneWord),
    .intrEmpty    (intrEmpty),
    .intrDma      (intrDma),
    .rxLow        (rxLow),
    .rxHigh       (rxHigh)
  );

endmodule

// File: rtl/rxcopy_chk.sv
module rxcopy_chk #(
  parameter int LEN_W  = 14,
  parameter int ADDR_W = 16,
  parameter int FLAG_W = 4,
  localparam int WORD_W = LEN_W + 3 + FLAG_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgZeroCopy,
  input logic              cfgDeferCopy,
  input logic [LEN_W-1:0]  cfgZcSize,
  input logic [LEN_W-1:0]  cfgZcThresh,
  input logic              newReqAck,
  input logic              contReqAck,
  input logic              dmaReqValid,
  input logic [ADDR_W-1:0] dmaAddr,
  input logic [LEN_W-1:0]  dmaLen,
  input logic [LEN_W-1:0]  dmaOffset,
  input logic              dmaDone,
  input logic              framePop,
  input logic              doneValid,
  input logic [WORD_W-1:0] doneWord,
  input logic              intrDma
);

  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (cfgZcSize < cfgZcThresh) && !(cfgZeroCopy && cfgDeferCopy)); // R10

  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    dmaReqValid && !dmaDone |=> dmaReqValid && $stable(dmaAddr)
      && $stable(dmaLen) && $stable(dmaOffset)); // R12

  AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !(newReqAck && contReqAck)); // R7

  AST_DONE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> doneWord[LEN_W+1] && intrDma); // R4

  AST_MORE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneWord[LEN_W] |-> !framePop); // R6

  AST_ERR_POP: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneWord[LEN_W+2] |-> framePop && (doneWord[LEN_W-1:0] == '0)); // R9

  AST_NO_SENTINEL_DMA: assert property (@(posedge clk) disable iff (!rstN)
    dmaReqValid |-> dmaAddr != ADDR_W'(1)); // R3

endmodule

bind rxcopy_top rxcopy_chk #(
  .LEN_W  (LEN_W),
  .ADDR_W (ADDR_W),
  .FLAG_W (FLAG_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgZeroCopy  (cfgZeroCopy),
  .cfgDeferCopy (cfgDeferCopy),
  .cfgZcSize    (cfgZcSize),
  .cfgZcThresh  (cfgZcThresh),
  .newReqAck    (newReqAck),
  .contReqAck   (contReqAck),
  .dmaReqValid  (dmaReqValid),
  .dmaAddr      (dmaAddr),
  .dmaLen       (dmaLen),
  .dmaOffset    (dmaOffset),
  .dmaDone      (dmaDone),
  .framePop     (framePop),
  .doneValid    (doneValid),
  .doneWord     (doneWord),
  .intrDma      (intrDma)
);

// File: tb/rxcopy_top_tb.sv
`timescale 1ns/1ps
module rxcopy_top_tb;

  localparam int LW = 14;
  localparam int AW = 16;
  localparam int FW = 4;
  localparam int CW = 4;
  localparam int TH = 16;
  localparam int ZS = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgZeroCopy = 1'b0, cfgDeferCopy = 1'b0;
  logic [LW-1:0] cfgZcSize = LW'(ZS), cfgZcThresh = LW'(TH);
  logic [CW-1:0] cfgLowMark = '0, cfgHighMark = CW'(1);
  logic [CW-1:0] fifoCount = '0;
  logic          frameValid = 1'b0;
  logic [LW-1:0] frameLen = '0;
  logic [FW-1:0] frameFlags = '0;
  logic          newReqValid = 1'b0, contReqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic          reqNoDelay = 1'b0;
  logic          newReqAck, contReqAck, dmaReqValid;
  logic [AW-1:0] dmaAddr;
  logic [LW-1:0] dmaLen, dmaOffset;
  logic          dmaDone = 1'b0;
  logic          framePop, doneValid, intrEmpty, intrDma, rxLow, rxHigh;
  logic [LW+3+FW-1:0] doneWord;

  always #4 clk = ~clk;

  rxcopy_top u_dut (
    .clk(clk), .rstN(rstN), .cfgZeroCopy(cfgZeroCopy), .cfgDeferCopy(cfgDeferCopy),
    .cfgZcSize(cfgZcSize), .cfgZcThresh(cfgZcThresh), .cfgLowMark(cfgLowMark),
    .cfgHighMark(cfgHighMark), .fifoCount(fifoCount), .frameValid(frameValid),
    .frameLen(frameLen), .frameFlags(frameFlags), .newReqValid(newReqValid),
    .contReqValid(contReqValid), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqNoDelay(reqNoDelay), .newReqAck(newReqAck), .contReqAck(contReqAck),
    .dmaReqValid(dmaReqValid), .dmaAddr(dmaAddr), .dmaLen(dmaLen),
    .dmaOffset(dmaOffset), .dmaDone(dmaDone), .framePop(framePop),
    .doneValid(doneValid), .doneWord(doneWord), .intrEmpty(intrEmpty),
    .intrDma(intrDma), .rxLow(rxLow), .rxHigh(rxHigh)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  // bench model
  int  mRem, mOff, mFc;
  bit  mLow = 1'b1, mHigh = 1'b0;
  logic [FW-1:0] mFlags;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic loadFrame(input int len, input int cnt);
    frameLen   = LW'(len);
    frameFlags = FW'(len) ^ 4'h5;
    mFc        = cnt;
    fifoCount  = CW'(cnt);
    frameValid = 1'b1;
  endtask

  // one copy request, from offer to completion, checked against the model
  task automatic doCopy(input bit cont, input int addr, input int blen,
                        input bit nd, input bit alsoNew, output bit fullOut);
    int expLen, lenF, guard, cntAfter;
    bit expFull, expCut;
    if (!cont) begin
      mRem = int'(frameLen); mOff = 0; mFlags = frameFlags;
    end
    expLen = (blen < mRem) ? blen : mRem;
    expCut = (cfgZeroCopy || cfgDeferCopy) && !nd && mLow && (expLen > TH);
    if (expCut) expLen = ZS;
    expFull = (expLen == mRem);
    lenF    = expFull ? expLen : (mRem - expLen);

    @(negedge clk);
    contReqValid = cont;
    newReqValid  = !cont || alsoNew;
    reqAddr      = AW'(addr);
    reqLen       = LW'(blen);
    reqNoDelay   = nd;
    #1;
    guard = 0;
    while (!(cont ? contReqAck : newReqAck) && guard < 50) begin
      @(negedge clk); #1; guard++;
    end
    chk(guard < 50, cont ? "R7 continuation accepted" : "R7 new accepted", guard, 0);
    if (alsoNew) chk(!newReqAck, "R7 continuation wins over new", int'(newReqAck), 0);
    @(negedge clk);
    newReqValid = 1'b0; contReqValid = 1'b0;
    @(negedge clk);
    if (addr == 1 || mRem == 0) begin
      chk(!dmaReqValid, "R3 R9 no dma issued", int'(dmaReqValid), 0);
    end else begin
      chk(dmaReqValid, "R1 dma requested", int'(dmaReqValid), 1);
      chk(int'(dmaLen) == expLen, expCut ? "R2 cut length" : "R1 clamped length",
          int'(dmaLen), expLen);
      chk(int'(dmaOffset) == mOff, "R6 offset", int'(dmaOffset), mOff);
      chk(int'(dmaAddr) == addr, "R12 address", int'(dmaAddr), addr);
      @(negedge clk);
      chk(dmaReqValid && int'(dmaLen) == expLen, "R12 request held", int'(dmaLen), expLen);
      dmaDone = 1'b1;
      @(negedge clk);
      dmaDone = 1'b0;
    end
    chk(doneValid, "R4 done valid", int'(doneValid), 1);
    chk(int'(doneWord[LW-1:0]) == lenF, expFull ? "R5 copied length" : "R6 remaining length",
        int'(doneWord[LW-1:0]), lenF);
    chk(doneWord[LW] == !expFull, "R6 more flag", int'(doneWord[LW]), int'(!expFull));
    chk(doneWord[LW+1], "R4 complete flag", int'(doneWord[LW+1]), 1);
    chk(doneWord[LW+2] == (mRem == 0), "R9 error flag", int'(doneWord[LW+2]), int'(mRem == 0));
    chk(doneWord[LW+3 +: FW] == mFlags, "R4 flags", int'(doneWord[LW+3 +: FW]), int'(mFlags));
    chk(framePop == expFull, "R5 pop", int'(framePop), int'(expFull));
    cntAfter = mFc - (expFull ? 1 : 0);
    chk(intrDma, "R8 dma interrupt", int'(intrDma), 1);
    chk(intrEmpty == (cntAfter == 0), "R8 empty interrupt", int'(intrEmpty), int'(cntAfter == 0));
    mLow  = (cntAfter < int'(cfgLowMark));
    mHigh = (cntAfter > int'(cfgHighMark));
    if (!expFull) begin
      mOff += expLen; mRem -= expLen;
    end
    @(negedge clk);
    mFc = cntAfter;
    fifoCount = CW'(cntAfter);
    frameValid = (cntAfter != 0);
    chk(rxLow == mLow, "R8 low flag", int'(rxLow), int'(mLow));
    chk(rxHigh == mHigh, "R8 high flag", int'(rxHigh), int'(mHigh));
    chk(!doneValid && !intrDma, "R4 single done cycle", int'(doneValid), 0);
    fullOut = expFull;
  endtask

  task automatic fullFrame(input int len, input int cnt, input int blen, input bit nd);
    bit full;
    int n;
    loadFrame(len, cnt);
    doCopy(1'b0, 16'h0100, blen, nd, 1'b0, full);
    n = 0;
    while (!full && n < 20) begin
      doCopy(1'b1, 16'h0200 + n, blen, nd, 1'b0, full);
      n++;
    end
    chk(full, "R6 frame finished", n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    bit full;
    int lens[5] = '{1, 9, 16, 17, 40};
    int bufs[3] = '{4, 16, 64};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(!newReqAck && !contReqAck && !dmaReqValid && !doneValid && !intrDma && !intrEmpty
        && !framePop, "R11 idle outputs", int'(doneValid), 0);
    chk(rxLow && !rxHigh, "R11 flags", int'(rxLow), 1);

    // R10: legal configuration sweep with R1/R2/R5/R6/R8
    for (int m = 0; m < 3; m++) begin
      cfgZeroCopy  = (m == 1);
      cfgDeferCopy = (m == 2);
      for (int nd = 0; nd < 2; nd++)
        for (int lm = 0; lm < 2; lm++) begin
          cfgLowMark = lm ? CW'(15) : CW'(0);
          for (int li = 0; li < 5; li++)
            for (int bi = 0; bi < 3; bi++)
              fullFrame(lens[li], (li + bi) % 3 + 1, bufs[bi], nd[0]);
        end
    end

    // R2: low flag forced on, cut applies with zero-copy
    cfgZeroCopy = 1'b1; cfgDeferCopy = 1'b0; cfgLowMark = CW'(15);
    fullFrame(40, 2, 64, 1'b0);

    // R3: sentinel address skips the DMA
    loadFrame(20, 1);
    doCopy(1'b0, 1, 64, 1'b1, 1'b0, full);

    // R9: zero-length frame
    loadFrame(0, 2);
    doCopy(1'b0, 16'h0300, 32, 1'b0, 1'b0, full);

    // R7: new request held off while a frame is partial, continuation preferred
    cfgZeroCopy = 1'b0;
    loadFrame(30, 3);
    doCopy(1'b0, 16'h0400, 4, 1'b0, 1'b0, full);
    @(negedge clk);
    newReqValid = 1'b1; reqAddr = 16'h0500; reqLen = LW'(64);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(!newReqAck, "R7 new held while partial", int'(newReqAck), 0);
    end
    newReqValid = 1'b0;
    doCopy(1'b1, 16'h0600, 8, 1'b0, 1'b1, full);
    while (!full) doCopy(1'b1, 16'h0700, 64, 1'b0, 1'b1, full);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule